// File: doc/BRIEF.md
# TDM Serial Frame Timing Generator

This block produces the timing skeleton of an 8 kHz time-division-multiplexed serial bus. One frame is always 1024 cycles of the block clock. The block clock is taken to run at 8.192 MHz, so one clock equals one bit at the highest line rate. A two-bit rate select picks 2.048, 4.096 or 8.192 Mbps. The channel count per frame follows from the rate: 32, 64 or 128 channels of eight bits each, sent most significant bit first. From a frame counter the block decodes the current channel number and bit index, a one-cycle strobe at the end of each channel, and a 4.096 MHz bit-clock output.

In master mode the block drives its own frame pulse. The pulse lasts two clocks, which is one 4.096 MHz period: the last clock of a frame and the first clock of the next. A control bit sets its polarity. In slave mode the output pulse stays at its inactive level and the block follows an incoming frame-sync signal instead. The block first watches that signal for one frame-length window and takes the level it holds most of the time as the inactive level. It then waits for the first active edge and aligns the counter to it. After that, every active edge is checked against the expected frame position, and an early or late edge raises a sticky error flag.

The mode sequencer has four states:
- ST_MASTER: the block generates the frame pulse.
- ST_LEARN: the block measures the polarity of the incoming signal.
- ST_SEEK: the polarity is known and the block waits for the first edge.
- ST_LOCK: the block is aligned and checks each pulse.

Its transitions are:
- master low: ST_MASTER → ST_LEARN.
- window end: ST_LEARN → ST_SEEK.
- first active edge: ST_SEEK → ST_LOCK.
- master high: any slave state → ST_MASTER.
- Reset: the sequencer enters ST_MASTER or ST_LEARN according to the master input.

Top module: `tdm_frame_timer`

## Requirements
- R1: With master_i high, the frame pulse is active for exactly two clocks of every 1024-clock frame: the cycle with frame count 1023 and the cycle with frame count 0. The frame count is the number of clocks since reset or since the last reload, modulo 1024.
- R2: With rate_i = 00 (2.048 Mbps), each bit lasts 4 clocks, chan_o runs 0 to 31, and bit_o counts 7 down to 0 within each channel.
- R3: With rate_i = 01 (4.096 Mbps), each bit lasts 2 clocks and chan_o runs 0 to 63.
- R4: With rate_i = 10 or 11 (8.192 Mbps), each bit lasts 1 clock and chan_o runs 0 to 127.
- R5: At rates 00 and 01, bclk_o is high on even frame counts and low on odd ones, which gives a 4.096 MHz clock. At rates 10 and 11, bclk_o stays low.
- R6: fp_o is low when active if pol_i = 0 and high when active if pol_i = 1. In slave mode, fp_o holds the inactive level.
- R7: last_o is high for exactly one clock per channel: the final clock of bit 0.
- R8: Right after reset, chan_o = 0, bit_o = 7 and ferr_o = 0.
- R9: In slave mode, the level that fs_i holds for more than half of the first 1024-clock window after reset or after leaving master mode is taken as inactive.
- R10: In slave mode, once the polarity is known, the first clock in which fs_i shows its active level (after a clock at the inactive level) becomes frame count 1023. The next clock is channel 0, bit 7.
- R11: In ST_LOCK, an active edge arriving at any frame count other than 1023 sets ferr_o. The flag then stays set until reset. Edges at count 1023 leave it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8.192 MHz block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| master_i | input | 1 | 1 = generate the frame pulse, 0 = follow fs_i |
| pol_i | input | 1 | Active level of fp_o |
| rate_i | input | 2 | Line rate: 00 = 2.048, 01 = 4.096, 1x = 8.192 Mbps |
| fs_i | input | 1 | Incoming frame sync, used in slave mode |
| fp_o | output | 1 | Generated frame pulse |
| bclk_o | output | 1 | 4.096 MHz bit clock (low at 8.192 Mbps) |
| chan_o | output | 7 | Current channel number |
| bit_o | output | 3 | Current bit index, 7 first |
| last_o | output | 1 | Strobe on the final clock of each channel |
| ferr_o | output | 1 | Sticky frame-alignment error |

## Verification
Master mode is run at every rate code with both polarities. This separates the 4-, 2- and 1-clock bit lengths and the 32/64/128 channel wrap, shows that code 11 behaves like 10, and catches an inverted pulse. Slave mode is run twice. The first run uses an idle-high signal with active-low pulses; the second uses an idle-low signal with active-high pulses. A wrongly detected polarity would align on the trailing edge of the two-clock pulse, so the expected channel 0, bit 7 position would appear two clocks late. In each slave run, pulses arrive first at an arbitrary count, then exactly one frame later, and then off-schedule. This tells the initial alignment apart from on-time pulses, which must not raise the error, and from misaligned pulses, which must raise it and keep it.

// File: rtl/tdmf_pkg.sv
package tdmf_pkg;

    typedef enum logic [1:0] {
        ST_MASTER = 2'd0,
        ST_LEARN  = 2'd1,
        ST_SEEK   = 2'd2,
        ST_LOCK   = 2'd3
    } sync_st_e;

    // log2 of clocks per bit for a rate code
    function automatic logic [1:0] rate_shift(input logic [1:0] rate);
        logic [1:0] s;
        unique case (rate)
            2'b00:   s = 2'd2;
            2'b01:   s = 2'd1;
            default: s = 2'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tdmf_frame_ctr.sv
module tdmf_frame_ctr #(
    parameter int FRAME_CLKS = 1024,
    parameter int CW         = $clog2(FRAME_CLKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);
    localparam logic [CW-1:0] LAST = CW'(FRAME_CLKS - 1);

    assign wrap_o = (cnt_o == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (load_i || wrap_o)
            cnt_o <= '0;
        else
            cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/tdmf_pos_dec.sv
module tdmf_pos_dec
    import tdmf_pkg::*;
#(
    parameter int BITS = 8,
    parameter int CW   = 10,
    parameter int BW   = $clog2(BITS),
    parameter int CHW  = CW - BW
) (
    input  logic [CW-1:0]  cnt_i,
    input  logic [1:0]     rate_i,
    output logic [CHW-1:0] chan_o,
    output logic [BW-1:0]  bit_o,
    output logic           last_o,
    output logic           bclk_o
);
    logic [1:0]    sh;
    logic [CW-1:0] pos;
    logic [CW-1:0] mask;

    always_comb begin
        sh     = rate_shift(rate_i);
        pos    = cnt_i >> sh;
        chan_o = CHW'(pos >> BW);
        bit_o  = BW'(BITS - 1) - pos[BW-1:0];
        mask   = (CW'(BITS) << sh) - CW'(1);
        last_o = ((cnt_i & mask) == mask);
        bclk_o = (sh != 2'd0) && !cnt_i[0];
    end
endmodule

// File: rtl/tdmf_pol_det.sv
module tdmf_pol_det #(
    parameter int WIN = 1024,
    parameter int WW  = $clog2(WIN)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic upd_i,
    input  logic lvl_i,
    output logic done_o,
    output logic act_hi_o
);
    localparam logic [WW:0] HALF = (WW+1)'(WIN / 2);

    logic [WW-1:0] wcnt;
    logic [WW:0]   hcnt;
    logic [WW:0]   total;

    assign done_o = (wcnt == WW'(WIN - 1));
    assign total  = hcnt + (WW+1)'(lvl_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt     <= '0;
            hcnt     <= '0;
            act_hi_o <= 1'b0;
        end else if (start_i) begin
            wcnt <= '0;
            hcnt <= '0;
        end else if (done_o) begin
            wcnt <= '0;
            hcnt <= '0;
            if (upd_i)
                act_hi_o <= (total < HALF);
        end else begin
            wcnt <= wcnt + 1'b1;
            hcnt <= total;
        end
    end
endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdmf_pkg::*;
#(
    parameter  int BASE_CH    = 32,
    parameter  int BITS       = 8,
    localparam int FRAME_CLKS = BASE_CH * BITS * 4,
    localparam int CW         = $clog2(FRAME_CLKS),
    localparam int BW         = $clog2(BITS),
    localparam int CHW        = CW - BW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           master_i,
    input  logic           pol_i,
    input  logic [1:0]     rate_i,
    input  logic           fs_i,
    output logic           fp_o,
    output logic           bclk_o,
    output logic [CHW-1:0] chan_o,
    output logic [BW-1:0]  bit_o,
    output logic           last_o,
    output logic           ferr_o
);
    sync_st_e      st_q, st_d;
    logic          fs_q;
    logic          act_hi;
    logic          pd_done;
    logic          edge_w;
    logic          load;
    logic          wrap;
    logic [CW-1:0] cnt;
    logic          fp_act;

    assign edge_w = (act_hi ? fs_i : ~fs_i) && !(act_hi ? fs_q : ~fs_q);
    assign load   = !master_i && (st_q == ST_SEEK || st_q == ST_LOCK) && edge_w;

    tdmf_frame_ctr #(.FRAME_CLKS(FRAME_CLKS), .CW(CW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load_i(load), .cnt_o(cnt), .wrap_o(wrap)
    );

    tdmf_pos_dec #(.BITS(BITS), .CW(CW), .BW(BW), .CHW(CHW)) u_dec (
        .cnt_i(cnt), .rate_i(rate_i), .chan_o(chan_o), .bit_o(bit_o),
        .last_o(last_o), .bclk_o(bclk_o)
    );

    tdmf_pol_det #(.WIN(FRAME_CLKS)) u_pol (
        .clk(clk), .rst_n(rst_n),
        .start_i(st_d == ST_LEARN && st_q != ST_LEARN),
        .upd_i(st_q == ST_LEARN), .lvl_i(fs_q),
        .done_o(pd_done), .act_hi_o(act_hi)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_MASTER: if (!master_i) st_d = ST_LEARN;
            ST_LEARN:  if (master_i) st_d = ST_MASTER;
                       else if (pd_done) st_d = ST_SEEK;
            ST_SEEK:   if (master_i) st_d = ST_MASTER;
                       else if (edge_w) st_d = ST_LOCK;
            ST_LOCK:   if (master_i) st_d = ST_MASTER;
            default:   st_d = ST_MASTER;
        endcase
    end

    // state register and sync history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= master_i ? ST_MASTER : ST_LEARN;
            fs_q   <= 1'b0;
            ferr_o <= 1'b0;
        end else begin
            st_q <= st_d;
            fs_q <= fs_i;
            if (load && st_q == ST_LOCK && !wrap)
                ferr_o <= 1'b1;
        end
    end

    // output pulse
    always_comb begin
        fp_act = (st_q == ST_MASTER) && (wrap || cnt == '0);
        fp_o   = pol_i ? fp_act : ~fp_act;
    end
endmodule

// File: rtl/tdmf_chk.sv
module tdmf_chk #(
    parameter int BW  = 3,
    parameter int CHW = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           master_i,
    input logic           pol_i,
    input logic [1:0]     rate_i,
    input logic           fp_o,
    input logic           bclk_o,
    input logic [CHW-1:0] chan_o,
    input logic [BW-1:0]  bit_o,
    input logic           last_o,
    input logic           ferr_o
);
    // R1
    fp_centre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && $past(master_i) && fp_o == pol_i)
            |-> ((chan_o == '0 && bit_o == '1) || last_o));

    // R6
    slave_fp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_i && !$past(master_i)) |-> (fp_o != pol_i));

    // R7
    last_on_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> (bit_o == '0));

    // R2
    msb_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && last_o) ##1 (master_i && $stable(rate_i)) |-> (bit_o == '1));

    // R5
    bclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_i[1] |-> !bclk_o);

    // R11
    ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ferr_o |=> ferr_o);
endmodule

bind tdm_frame_timer tdmf_chk #(.BW(BW), .CHW(CHW)) u_chk (
    .clk(clk), .rst_n(rst_n), .master_i(master_i), .pol_i(pol_i),
    .rate_i(rate_i), .fp_o(fp_o), .bclk_o(bclk_o), .chan_o(chan_o),
    .bit_o(bit_o), .last_o(last_o), .ferr_o(ferr_o)
);

// File: tb/sim_tdm_frame_timer.sv
`timescale 1ns/1ps
module sim_tdm_frame_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_i = 1'b1;
    logic       pol_i = 1'b0;
    logic [1:0] rate_i = 2'b00;
    logic       fs_i = 1'b0;
    logic       fp_o, bclk_o, last_o, ferr_o;
    logic [6:0] chan_o;
    logic [2:0] bit_o;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    int    m = 0;
    bit    reload = 0;
    bit    exp_ferr = 0;
    bit    locked = 0;
    string pos_tag = "R2";

    always #10 clk = ~clk;

    tdm_frame_timer u0 (
        .clk(clk), .rst_n(rst_n), .master_i(master_i), .pol_i(pol_i),
        .rate_i(rate_i), .fs_i(fs_i), .fp_o(fp_o), .bclk_o(bclk_o),
        .chan_o(chan_o), .bit_o(bit_o), .last_o(last_o), .ferr_o(ferr_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s at count %0d: actual=%0d expected=%0d", tag, what, m, act, exp);
        end
    endtask

    task automatic check_all();
        int sh, pos, mask;
        bit fpa;
        sh   = (rate_i == 2'b00) ? 2 : (rate_i == 2'b01) ? 1 : 0;
        pos  = m >> sh;
        mask = (8 << sh) - 1;
        fpa  = master_i && (m == 1023 || m == 0);
        chk(pos_tag, "chan", chan_o, pos >> 3);
        chk(pos_tag, "bit", bit_o, 7 - (pos & 7));
        chk("R7", "last", last_o, ((m & mask) == mask) ? 1 : 0);
        chk("R5", "bclk", bclk_o, (sh != 0 && (m % 2) == 0) ? 1 : 0);
        chk(master_i ? "R1" : "R6", "fp", fp_o, pol_i ? fpa : !fpa);
        chk("R11", "ferr", ferr_o, exp_ferr);
    endtask

    task automatic step();
        @(negedge clk);
        m = reload ? 0 : (m + 1) % 1024;
        reload = 0;
        check_all();
    endtask

    task automatic do_reset(input bit mst, input logic [1:0] rt, input bit pl, input bit fs);
        @(negedge clk);
        rst_n = 0; master_i = mst; rate_i = rt; pol_i = pl; fs_i = fs;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m = 0; reload = 0; exp_ferr = 0; locked = 0;
        chk("R8", "reset chan", chan_o, 0);
        chk("R8", "reset bit", bit_o, 7);
        chk("R8", "reset ferr", ferr_o, 0);
    endtask

    task automatic t_master(input logic [1:0] rt, input bit pl, input string tag);
        pos_tag = tag;
        do_reset(1, rt, pl, 0);
        repeat (1030) step();
    endtask

    // drive a two-clock pulse starting in the current cycle
    task automatic pulse(input bit act_lvl);
        fs_i = act_lvl;
        if (locked && m != 1023) exp_ferr = 1;
        reload = 1;
        locked = 1;
        step();
        step();
        fs_i = !act_lvl;
    endtask

    task automatic t_slave(input logic [1:0] rt, input bit act_lvl, input string tag);
        pos_tag = "R9";
        do_reset(0, rt, 0, !act_lvl);
        repeat (1100) step();
        pos_tag = tag;
        pulse(act_lvl);               // R10 first alignment
        while (m != 1023) step();
        pulse(act_lvl);               // on time: no error, R11
        repeat (40) step();
        chk("R11", "ferr after on-time pulse", ferr_o, 0);
        pulse(act_lvl);               // off schedule: error, realign
        repeat (1100) step();
        chk("R11", "ferr held", ferr_o, 1);
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_master(2'b00, 0, "R2");
        t_master(2'b01, 1, "R3");
        t_master(2'b10, 0, "R4");
        t_master(2'b11, 1, "R4");
        t_slave(2'b10, 0, "R10");
        t_slave(2'b00, 1, "R9");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule